// File: doc/BRIEF.md
# Multi-Channel Timebase Timer

This block is a register-mapped timer unit for an SoC. It holds four independent countdown event channels (0 to 3) and one 32-bit free-running up-counter. All of them step on single-cycle tick enables. A shared divider chain derives these ticks from the system clock: one tick per microsecond, then per 10 µs, 100 µs and 1 ms. The system clock is assumed to be an integer number of cycles per microsecond, set by `SYS_PER_US`.

A single control word holds, for each countdown channel, a run enable, a periodic/one-shot flag and a 2-bit tick-rate select. It also holds a 3-bit rate select for the up-counter. To arm a channel, software clears its run bit, writes a load value to the channel's count register, then sets the run bit together with the chosen mode. The channel expires one tick after its count reaches zero and then emits a one-clock interrupt pulse. In periodic mode the channel reloads and keeps running. In one-shot mode it stops and clears its own run bit.

The bus is a plain synchronous write strobe with a combinational read of the addressed word.

Top module: `tick_timer_unit`

## Requirements
- R1: While reset is asserted and right after it, the control word, all four channel counts and the up-counter read zero, and `evt_irq` is all zero.
- R2: The control word is at byte offset 0x00. Bits 19:12 and 10:0 are writable. Bits 31:20 and bit 11 ignore writes and always read zero.
- R3: The count register of channel i is at offset 0x04 + 4·i and is 16 bits wide. A write loads both the live count and the reload value from data bits 15:0. A read returns the live count, zero-extended.
- R4: Control bit 16 + i is the run bit of channel i. A channel whose run bit is clear keeps its count unchanged.
- R5: A running channel decrements once per selected tick. After a load value L it expires on the (L+1)-th tick, and the live count is readable at any time.
- R6: Control bits 2i+1:2i select the tick of channel i: 0 = 1 µs, 1 = 10 µs, 2 = 100 µs, 3 = 1 ms. One µs is `SYS_PER_US` clock cycles, and each step up is ten times the one below.
- R7: Control bit 12 + i set to 1 makes channel i periodic. On expiry it reloads the last written value and keeps running, giving one expiry every L+1 ticks, and its run bit stays set.
- R8: Control bit 12 + i set to 0 makes channel i one-shot. On expiry its count stays at zero, its run bit clears by itself, and no further interrupt follows.
- R9: Each expiry of channel i drives `evt_irq[i]` high for exactly one clock cycle.
- R10: The up-counter is at offset 0x14 and is read-only; writes there are ignored. Control bits 10:8 select its step: 0 = every clock, 1 = 1 µs, 2 = 10 µs, 3 = 100 µs, 4 = 1 ms, 5 to 7 = hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for the addressed word |
| bus_addr | input | 5 | Byte offset of the accessed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the word at `bus_addr` |
| evt_irq | output | 4 | One-clock expiry pulse per countdown channel |

## Verification
On every cycle, the assertions check these properties:
- an idle channel holds its count;
- a periodic channel is back at its reload value in the cycle its pulse is seen;
- a one-shot pulse always coincides with a cleared run bit unless software wrote the control word;
- the tick enables nest properly;
- the up-counter steps by one per clock when selected and freezes on the hold codes.

Only the bench scenarios can show the absolute timing: the cycle distance between periodic pulses for each rate code and load value, the live count after a known number of ticks, the register masks and read-back, and that a one-shot channel stays silent after its single expiry.

// File: rtl/ttu_pkg.sv
package ttu_pkg;
  localparam int DATA_W   = 32;
  localparam int CH_NUM   = 4;
  localparam int RATE_NUM = 4;
  localparam int EN_LSB   = 16;
  localparam int MODE_LSB = 12;
  localparam int UPSEL_LSB = 8;
  localparam int OFS_CTRL = 'h00;
  localparam int OFS_CNT0 = 'h04;
  localparam int OFS_UP   = 'h14;
  localparam logic [DATA_W-1:0] CTRL_MASK = 32'h000F_F7FF;
endpackage

// File: rtl/ttu_tickgen.sv
module ttu_tickgen #(
  parameter int SYS_PER_US = 100
) (
  input  logic                          clk,
  input  logic                          rst_n,
  output logic [ttu_pkg::RATE_NUM-1:0]  tick
);
  localparam int PRE_W = (SYS_PER_US > 1) ? $clog2(SYS_PER_US) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(SYS_PER_US - 1);

  logic [PRE_W-1:0] pre_q, pre_d;

  always_comb begin
    pre_d = pre_q;
    if (pre_q == PRE_LAST) pre_d = '0;
    else                   pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_d;
  end

  assign tick[0] = (pre_q == PRE_LAST);

  for (genvar k = 1; k < ttu_pkg::RATE_NUM; k++) begin : g_decade
    logic [3:0] dec_q, dec_d;
    always_comb begin
      dec_d = dec_q;
      if (tick[k-1]) dec_d = (dec_q == 4'd9) ? 4'd0 : dec_q + 4'd1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) dec_q <= '0;
      else        dec_q <= dec_d;
    end
    assign tick[k] = tick[k-1] && (dec_q == 4'd9);

    a_r6_tick_nested: assert property (@(posedge clk) disable iff (!rst_n)
      tick[k] |-> tick[k-1]);
  end

  if (SYS_PER_US > 1) begin : g_spacing
    a_r6_us_spaced: assert property (@(posedge clk) disable iff (!rst_n)
      tick[0] |=> !tick[0]);
  end
endmodule

// File: rtl/ttu_countdown.sv
module ttu_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             en,
  input  logic             periodic,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             clr_en
);
  logic [CNT_W-1:0] cnt_q, cnt_d, rel_q, rel_d;
  logic             irq_q, irq_d;
  logic             fire;

  assign fire = en && tick && (cnt_q == '0);

  always_comb begin
    cnt_d  = cnt_q;
    rel_d  = rel_q;
    irq_d  = 1'b0;
    clr_en = 1'b0;
    if (ld) begin
      cnt_d = ld_val;
      rel_d = ld_val;
    end else if (fire) begin
      cnt_d  = periodic ? rel_q : '0;
      irq_d  = 1'b1;
      clr_en = !periodic;
    end else if (en && tick) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= '0;
      irq_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      rel_q <= rel_d;
      irq_q <= irq_d;
    end
  end

  assign cnt = cnt_q;
  assign irq = irq_q;

  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !ld) |=> $stable(cnt_q));

  a_r7_reloaded: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && $past(periodic)) |-> (cnt_q == rel_q));
endmodule

// File: rtl/ttu_upcount.sv
module ttu_upcount #(
  parameter int UP_W = 32
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [2:0]                    sel,
  input  logic [ttu_pkg::RATE_NUM-1:0]  tick,
  output logic [UP_W-1:0]               cnt
);
  logic [UP_W-1:0] cnt_q, cnt_d;
  logic            step;

  always_comb begin
    case (sel)
      3'd0:    step = 1'b1;
      3'd1:    step = tick[0];
      3'd2:    step = tick[1];
      3'd3:    step = tick[2];
      3'd4:    step = tick[3];
      default: step = 1'b0;
    endcase
    cnt_d = step ? cnt_q + 1'b1 : cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  a_r10_every_clock: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == 3'd0) |=> (cnt_q == $past(cnt_q) + 1'b1));

  a_r10_hold_codes: assert property (@(posedge clk) disable iff (!rst_n)
    (sel > 3'd4) |=> $stable(cnt_q));
endmodule

// File: rtl/tick_timer_unit.sv
module tick_timer_unit
  import ttu_pkg::*;
#(
  parameter int SYS_PER_US = 100,
  parameter int CNT_W      = 16,
  parameter int UP_W       = 32,
  parameter int ADDR_W     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [CH_NUM-1:0] evt_irq
);
  // reset: asynchronous assertion, synchronous release
  logic rst_meta, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  logic [DATA_W-1:0]   ctrl_q, ctrl_d;
  logic                ctrl_wr;
  logic [RATE_NUM-1:0] tick_v;
  logic [CH_NUM-1:0]   clr_en;
  logic [CNT_W-1:0]    cnt_v [CH_NUM];
  logic [UP_W-1:0]     up_cnt;

  assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(OFS_CTRL));

  ttu_tickgen #(.SYS_PER_US(SYS_PER_US)) i_tickgen (
    .clk  (clk),
    .rst_n(rst_s),
    .tick (tick_v)
  );

  for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
    logic ch_ld;
    logic ch_tick;
    assign ch_ld   = bus_wr && (bus_addr == ADDR_W'(OFS_CNT0 + 4*i));
    assign ch_tick = tick_v[ctrl_q[2*i +: 2]];

    ttu_countdown #(.CNT_W(CNT_W)) i_cd (
      .clk     (clk),
      .rst_n   (rst_s),
      .tick    (ch_tick),
      .en      (ctrl_q[EN_LSB+i]),
      .periodic(ctrl_q[MODE_LSB+i]),
      .ld      (ch_ld),
      .ld_val  (bus_wdata[CNT_W-1:0]),
      .cnt     (cnt_v[i]),
      .irq     (evt_irq[i]),
      .clr_en  (clr_en[i])
    );

    a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_s)
      (evt_irq[i] && !$past(ctrl_wr) && !$past(ctrl_q[MODE_LSB+i]))
        |-> !ctrl_q[EN_LSB+i]);
  end

  ttu_upcount #(.UP_W(UP_W)) i_up (
    .clk  (clk),
    .rst_n(rst_s),
    .sel  (ctrl_q[UPSEL_LSB +: 3]),
    .tick (tick_v),
    .cnt  (up_cnt)
  );

  // control word: a bus write overrides a same-cycle self clear
  always_comb begin
    ctrl_d = ctrl_q;
    for (int i = 0; i < CH_NUM; i++)
      if (clr_en[i]) ctrl_d[EN_LSB+i] = 1'b0;
    if (ctrl_wr) ctrl_d = bus_wdata & CTRL_MASK;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) ctrl_q <= '0;
    else        ctrl_q <= ctrl_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == ADDR_W'(OFS_CTRL)) bus_rdata = ctrl_q;
    if (bus_addr == ADDR_W'(OFS_UP))   bus_rdata = DATA_W'(up_cnt);
    for (int i = 0; i < CH_NUM; i++)
      if (bus_addr == ADDR_W'(OFS_CNT0 + 4*i)) bus_rdata = DATA_W'(cnt_v[i]);
  end

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_s)
    ctrl_wr |=> ((ctrl_q & ~CTRL_MASK) == '0));
endmodule

// File: tb/test_tick_timer_unit.sv
`timescale 1ns/1ps
module test_tick_timer_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [3:0]  evt_irq;

  always #2 clk = ~clk;

  tick_timer_unit #(.SYS_PER_US(4)) i_tick_timer_unit (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_irq(evt_irq)
  );

  int nchk = 0, nerr = 0, wide_err = 0;
  bit done = 0;
  longint cyc = 0;
  longint last_t [4];
  longint ivl [4];
  int     irq_cnt [4];
  logic [3:0] prev_irq = '0;

  // channel, rate code, load value, expected cycles between pulses (1 us = 4 clocks)
  localparam int V_CH   [8] = '{0, 1, 2, 3, 0, 1, 2, 3};
  localparam int V_RATE [8] = '{0, 1, 2, 3, 1, 0, 0, 2};
  localparam int V_LOAD [8] = '{2, 1, 0, 0, 3, 0, 9, 1};
  localparam int V_IVL  [8] = '{12, 80, 400, 4000, 160, 4, 40, 800};

  initial for (int i = 0; i < 4; i++) begin last_t[i] = 0; ivl[i] = 0; irq_cnt[i] = 0; end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    for (int i = 0; i < 4; i++) begin
      if (evt_irq[i]) begin
        ivl[i]     <= cyc - last_t[i];
        last_t[i]  <= cyc;
        irq_cnt[i] <= irq_cnt[i] + 1;
        if (prev_irq[i]) wide_err <= wide_err + 1;
      end
    end
    prev_irq <= evt_irq;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    logic [31:0] v, v2;
    int base;
    // R1: reset state
    repeat (3) @(negedge clk);
    rd(5'h00, v); chk("R1 ctrl", v, 0);
    for (int i = 0; i < 4; i++) begin rd(5'(4 + 4*i), v); chk("R1 count", v, 0); end
    rd(5'h14, v); chk("R1 upcounter", v, 0);
    chk("R1 irq", {28'd0, evt_irq}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(5'h00, v); chk("R1 ctrl after release", v, 0);

    // R2: reserved control bits
    wr(5'h00, 32'hFFFF_FFFF);
    wr(5'h00, 32'hFFFF_FFFF & ~32'h000F_0000);
    rd(5'h00, v); chk("R2 mask", v, 32'h0000_F7FF);
    wr(5'h00, 32'h0);

    // R3: 16-bit count register, upper bits dropped
    wr(5'h04, 32'h0001_2345);
    rd(5'h04, v); chk("R3 count width", v, 32'h2345);

    // R4: disabled channel holds
    wr(5'h08, 32'd5);
    repeat (100) @(negedge clk);
    rd(5'h08, v); chk("R4 idle hold", v, 5);

    // R5: live countdown, 10 ticks of 1 us in 40 clocks
    wr(5'h0C, 32'd100);
    wr(5'h00, 32'h0004_0000);
    repeat (40) @(negedge clk);
    rd(5'h0C, v); chk("R5 live count", v, 90);
    wr(5'h00, 32'h0);

    // R6/R7: periodic vector table
    for (int n = 0; n < 8; n++) begin
      wr(5'h00, 32'h0);
      wr(5'(4 + 4*V_CH[n]), 32'(V_LOAD[n]));
      wr(5'h00, (32'd1 << (16 + V_CH[n])) | (32'd1 << (12 + V_CH[n])) |
                (32'(V_RATE[n]) << (2 * V_CH[n])));
      base = irq_cnt[V_CH[n]];
      while (irq_cnt[V_CH[n]] < base + 3) @(negedge clk);
      @(negedge clk);
      chk("R6 R7 periodic interval", 32'(ivl[V_CH[n]]), 32'(V_IVL[n]));
      rd(5'h00, v); chk("R7 run bit kept", 32'(v[16 + V_CH[n]]), 1);
    end
    wr(5'h00, 32'h0);

    // R8: one-shot on channel 0, load 3
    wr(5'h04, 32'd3);
    base = irq_cnt[0];
    wr(5'h00, 32'h0001_0000);
    while (irq_cnt[0] < base + 1) @(negedge clk);
    @(negedge clk);
    rd(5'h00, v); chk("R8 run bit cleared", v, 0);
    rd(5'h04, v); chk("R8 count at zero", v, 0);
    repeat (200) @(negedge clk);
    chk("R8 single pulse", 32'(irq_cnt[0] - base), 1);

    // R9: every pulse one clock wide
    chk("R9 pulse width", 32'(wide_err), 0);

    // R10: up-counter steps
    rd(5'h14, v); repeat (10) @(negedge clk); rd(5'h14, v2);
    chk("R10 every clock", v2 - v, 10);
    wr(5'h00, 32'h0000_0100);
    rd(5'h14, v); repeat (40) @(negedge clk); rd(5'h14, v2);
    chk("R10 1us step", v2 - v, 10);
    wr(5'h00, 32'h0000_0400);
    rd(5'h14, v); repeat (8000) @(negedge clk); rd(5'h14, v2);
    chk("R10 1ms step", v2 - v, 2);
    wr(5'h00, 32'h0000_0500);
    rd(5'h14, v); repeat (50) @(negedge clk); rd(5'h14, v2);
    chk("R10 hold code", v2, v);
    wr(5'h14, 32'h0);
    rd(5'h14, v2); chk("R10 write ignored", v2, v);

    finish_run();
  end
endmodule